// File: doc/BRIEF.md
# PLL Hold and Reset Controller

This block produces the digital control signals of a clock-synchronizer PLL: a charge-pump tri-state enable, a clear for the reference, feedback and output divider counters, and a force-static request for the clock outputs. All three come from one active-low control input. A mode input gives that input one of two meanings. In RESET mode the loop is stopped: the charge pump is tri-stated, the counters are cleared and the outputs are held static. The programmed divider ratios stay where they are stored, outside this block. In HOLD mode only the charge pump is tri-stated, so the loop holds its frequency while the dividers and outputs keep running.

A register bit can request the same function as the pin. The two requests are combined as a logical OR. The pin is asynchronous, so it passes through a synchronizer into the system clock domain first. When HOLD ends, the charge pump is not re-enabled at once. It waits for the next reference clock edge that is flagged valid, and it stays tri-stated for as long as no valid reference arrives. An asynchronous active-low power-down input overrides both modes.

Top module: `pll_hold_reset_ctrl`

## Requirements
- R1: `hold_sel` chooses the meaning of the control function. The value 0 selects RESET and the value 1 selects HOLD. The same pin and register stimulus gives the output pattern of the selected mode.
- R2: The control function is active when `force_req` is 1 or the synchronized `ctl_n` is 0, the logical OR of the two active states. `force_req` acts without a clock edge.
- R3: In RESET mode with the function active, `cp_tristate`, `div_clear` and `out_static` are all 1. With the function inactive, all three are 0 and no reference edge is awaited.
- R4: RESET is level sensitive. When the function becomes inactive, the outputs fall without any clock edge, and nothing of an earlier request is retained.
- R5: A change on `ctl_n` reaches the outputs after the second rising clock edge that samples it, and not after the first.
- R6: In HOLD mode with the function active, `cp_tristate` is 1 while `div_clear` and `out_static` stay 0.
- R7: After HOLD is released, `cp_tristate` stays 1 until a rising clock edge at which `ref_valid` and `ref_edge` are both 1 and the function is inactive. It is 0 right after that edge. Reference edges seen while the function is still active, or seen without `ref_valid`, do not end the wait.
- R8: While `pd_n` is 0, all three outputs are 1 without waiting for a clock edge. A pending HOLD wait is discarded, so after `pd_n` returns to 1 with the function inactive, `cp_tristate` is 0.
- R9: Setting `hold_sel` to 0 while a HOLD wait is pending drops the wait. With the function inactive, `cp_tristate` falls at once, and stays 0 when HOLD mode is selected again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pd_n | input | 1 | Asynchronous power-down, active low; also clears all state |
| ctl_n | input | 1 | Asynchronous control pin, active low |
| hold_sel | input | 1 | Mode: 0 = RESET, 1 = HOLD |
| force_req | input | 1 | Register request for the control function, active high |
| ref_valid | input | 1 | Reference clock currently judged valid |
| ref_edge | input | 1 | One-cycle strobe per reference clock rising edge |
| cp_tristate | output | 1 | Place the charge pump in tri-state |
| div_clear | output | 1 | Clear all divider counters to zero |
| out_static | output | 1 | Hold the clock outputs at their static levels |

## Verification
A sweep over all eight settled combinations of mode, register request and pin level separates the mode decoding from the OR of the two request sources. Separate edge-by-edge sequences on the pin show whether the synchronizer has exactly two stages. After a HOLD release, the bench tries the four combinations of `ref_valid` and `ref_edge`, and a reference edge that arrives while the function is still active. These separate a correct release from one that uses unqualified edges or edges seen too early. Power-down in the middle of a wait, and a mode change in the middle of a wait, show whether the pending state is discarded.

// File: rtl/pll_hr_pkg.sv
package pll_hr_pkg;

  typedef enum logic {
    FN_RESET = 1'b0,
    FN_HOLD  = 1'b1
  } fn_mode_e;

  // Function is active when either source requests it (pin is active low).
  function automatic logic fn_active(input logic pin_sync_n, input logic reg_req);
    return (~pin_sync_n) | reg_req;
  endfunction

  // A reference edge counts only when the reference is flagged valid.
  function automatic logic ref_release(input logic valid, input logic edge_stb);
    return valid & edge_stb;
  endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int STAGES = 2,
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic pd_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge pd_n) begin
    if (!pd_n) begin
      chain_q <= {STAGES{IDLE}};
    end else begin
      chain_q[0] <= d_async;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hold_tracker.sv
module hold_tracker (
  input  logic clk,
  input  logic pd_n,
  input  logic hold_mode,
  input  logic active,
  input  logic ref_ok,
  output logic wait_q
);
  logic wait_d;

  always_comb begin
    wait_d = hold_mode & (active | (wait_q & ~ref_ok));
  end

  always_ff @(posedge clk or negedge pd_n) begin
    if (!pd_n) wait_q <= 1'b0;
    else       wait_q <= wait_d;
  end

  // R7
  hold_arms_chk: assert property (@(posedge clk) disable iff (!pd_n)
    (hold_mode && active) |=> wait_q);

  // R7
  wait_keeps_chk: assert property (@(posedge clk) disable iff (!pd_n)
    (hold_mode && wait_q && !ref_ok) |=> wait_q);

  // R7
  wait_exit_chk: assert property (@(posedge clk) disable iff (!pd_n)
    $fell(wait_q) |-> ($past(ref_ok && !active) || !$past(hold_mode)));
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode (
  input  logic pd_n,
  input  logic hold_mode,
  input  logic active,
  input  logic wait_q,
  output logic cp_tristate,
  output logic div_clear,
  output logic out_static
);
  logic stop_loop;

  always_comb begin
    stop_loop   = active & ~hold_mode;
    cp_tristate = ~pd_n | active | (hold_mode & wait_q);
    div_clear   = ~pd_n | stop_loop;
    out_static  = ~pd_n | stop_loop;
  end

  // R8
  always_comb begin
    if (pd_n === 1'b0) begin
      pd_force_chk: assert (cp_tristate && div_clear && out_static);
    end
  end
endmodule

// File: rtl/pll_hold_reset_ctrl.sv
module pll_hold_reset_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic pd_n,
  input  logic ctl_n,
  input  logic hold_sel,
  input  logic force_req,
  input  logic ref_valid,
  input  logic ref_edge,
  output logic cp_tristate,
  output logic div_clear,
  output logic out_static
);
  import pll_hr_pkg::*;

  fn_mode_e mode;
  logic     pin_sync_n;
  logic     fn_on;
  logic     ref_ok;
  logic     hold_wait;

  assign mode = fn_mode_e'(hold_sel);

  ctl_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk    (clk),
    .pd_n   (pd_n),
    .d_async(ctl_n),
    .q_sync (pin_sync_n)
  );

  assign fn_on  = fn_active(pin_sync_n, force_req);
  assign ref_ok = ref_release(ref_valid, ref_edge);

  hold_tracker u_hold (
    .clk      (clk),
    .pd_n     (pd_n),
    .hold_mode(mode == FN_HOLD),
    .active   (fn_on),
    .ref_ok   (ref_ok),
    .wait_q   (hold_wait)
  );

  ctl_decode u_dec (
    .pd_n       (pd_n),
    .hold_mode  (mode == FN_HOLD),
    .active     (fn_on),
    .wait_q     (hold_wait),
    .cp_tristate(cp_tristate),
    .div_clear  (div_clear),
    .out_static (out_static)
  );

  // R3
  reset_stops_chk: assert property (@(posedge clk) disable iff (!pd_n)
    (!hold_sel && force_req) |-> (cp_tristate && div_clear && out_static));

  // R6
  hold_keeps_run_chk: assert property (@(posedge clk) disable iff (!pd_n)
    hold_sel |-> (!div_clear && !out_static));

  // R2
  force_tri_chk: assert property (@(posedge clk) disable iff (!pd_n)
    force_req |-> cp_tristate);

  // R9
  reset_no_wait_chk: assert property (@(posedge clk) disable iff (!pd_n)
    (!hold_sel && !div_clear) |-> !cp_tristate);
endmodule

// File: tb/pll_hold_reset_ctrl_test.sv
`timescale 1ns/1ps
module pll_hold_reset_ctrl_test;
  logic clk = 1'b0;
  logic pd_n, ctl_n, hold_sel, force_req, ref_valid, ref_edge;
  logic cp_tristate, div_clear, out_static;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pll_hold_reset_ctrl uut (
    .clk(clk), .pd_n(pd_n), .ctl_n(ctl_n), .hold_sel(hold_sel),
    .force_req(force_req), .ref_valid(ref_valid), .ref_edge(ref_edge),
    .cp_tristate(cp_tristate), .div_clear(div_clear), .out_static(out_static)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic chk3(input string tag, input logic cp, input logic clr, input logic st);
    chk(tag, "cp_tristate", cp_tristate, cp);
    chk(tag, "div_clear", div_clear, clr);
    chk(tag, "out_static", out_static, st);
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    pd_n = 1'b0; ctl_n = 1'b1; hold_sel = 1'b0; force_req = 1'b0;
    ref_valid = 1'b0; ref_edge = 1'b0;
    #1;
    chk3("R8", 1'b1, 1'b1, 1'b1);
    step(2);
    pd_n = 1'b1;
    step(3);
    chk3("R3", 1'b0, 1'b0, 1'b0);

    // RESET mode through the register bit
    force_req = 1'b1; #1;
    chk3("R2", 1'b1, 1'b1, 1'b1);
    step(1);
    chk3("R3", 1'b1, 1'b1, 1'b1);
    force_req = 1'b0; #1;
    chk3("R4", 1'b0, 1'b0, 1'b0);

    // Pin latency through the synchronizer
    ctl_n = 1'b0;
    step(1);
    chk("R5", "div_clear after 1 edge", div_clear, 1'b0);
    step(1);
    chk3("R5", 1'b1, 1'b1, 1'b1);
    ctl_n = 1'b1;
    step(1);
    chk("R5", "div_clear 1 edge after release", div_clear, 1'b1);
    step(1);
    chk3("R4", 1'b0, 1'b0, 1'b0);

    // HOLD mode and release rules
    hold_sel = 1'b1; force_req = 1'b1;
    step(1);
    chk3("R6", 1'b1, 1'b0, 1'b0);
    ref_valid = 1'b1; ref_edge = 1'b1;
    step(1);
    force_req = 1'b0; ref_edge = 1'b0;
    step(1);
    chk("R7", "edge during hold ignored", cp_tristate, 1'b1);
    ref_valid = 1'b0; ref_edge = 1'b1;
    step(2);
    chk("R7", "edge without valid ignored", cp_tristate, 1'b1);
    chk3("R6", 1'b1, 1'b0, 1'b0);
    ref_valid = 1'b1; ref_edge = 1'b1;
    step(1);
    chk("R7", "valid edge releases", cp_tristate, 1'b0);
    ref_valid = 1'b0; ref_edge = 1'b0;

    // HOLD via pin
    ctl_n = 1'b0;
    step(2);
    chk3("R6", 1'b1, 1'b0, 1'b0);
    ctl_n = 1'b1;
    step(5);
    chk("R7", "pin hold waits for ref", cp_tristate, 1'b1);
    ref_valid = 1'b1; ref_edge = 1'b1;
    step(1);
    chk("R7", "pin hold released", cp_tristate, 1'b0);
    ref_valid = 1'b0; ref_edge = 1'b0;

    // Mode change drops a pending wait
    force_req = 1'b1; step(1);
    force_req = 1'b0; step(1);
    chk("R7", "wait pending", cp_tristate, 1'b1);
    hold_sel = 1'b0; #1;
    chk("R9", "cp after switch to RESET", cp_tristate, 1'b0);
    step(1);
    hold_sel = 1'b1; #1;
    chk("R9", "wait gone after return to HOLD", cp_tristate, 1'b0);

    // Power-down during a pending wait
    force_req = 1'b1; step(1);
    force_req = 1'b0; step(1);
    #0.5;
    pd_n = 1'b0; #0.5;
    chk3("R8", 1'b1, 1'b1, 1'b1);
    step(1);
    pd_n = 1'b1;
    step(1);
    chk("R8", "wait discarded by power-down", cp_tristate, 1'b0);

    // Sweep: mode x register request x pin
    for (int m = 0; m < 2; m++) begin
      for (int r = 0; r < 2; r++) begin
        for (int p = 0; p < 2; p++) begin
          logic act;
          hold_sel = 1'b0; force_req = 1'b0; ctl_n = 1'b1;
          step(3);
          hold_sel = m[0]; force_req = r[0]; ctl_n = p[0];
          step(3);
          act = r[0] | ~p[0];
          chk("R1", "sweep cp", cp_tristate, act);
          chk("R1", "sweep clr", div_clear, act & ~m[0]);
          chk("R1", "sweep static", out_static, act & ~m[0]);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule